// File: doc/BRIEF.md
# Predicated Vector Add Sequencer

This block runs a single add operation, written with scalar register numbers, as a loop of element operations over a shared integer register file. Each register can carry a vector tag and a length. A tagged operand walks upward through consecutive registers, one register per element. An untagged operand stays on its base register. One opcode therefore covers the scalar-scalar, scalar-vector and vector-vector forms.

An integer register holds the predicate as a bit mask. Bit i enables element i. An element whose bit is clear produces no write, so its destination register keeps its old contents; nothing is zeroed.

A start pulse captures the operand numbers, the global length, the destination's length and the tags of the three operands. In that same cycle the predicate is read through the first read port. From the next cycle the block issues one element per clock on two read ports and one write port. It then pulses done. If an element would touch a register number beyond the file, the block stops early and raises an error flag.

Top module: `pvec_add_seq`

## Requirements
- R1: The element count n is the smallest of three values: the global length, the destination register's length and XLEN. Element i, for i from 0 to n-1, is issued in the (i+1)-th cycle after the cycle that accepts start, one element per cycle. busy is high in exactly those cycles.
- R2: The predicate is the content of register op_pred, read in the cycle that accepts start. Element i writes only when bit i of that word is 1. A later change to that register does not alter the running loop.
- R3: For element i, the destination register is op_rd+i when op_rd is tagged and op_rd otherwise. The same rule applies to op_rs1 and to op_rs2. A tag is bit r of vec_tag for register r.
- R4: Offsets advance on every element whether or not the element is enabled. A disabled element still uses up its register position.
- R5: An enabled element writes the 32-bit wrapping sum of the two source registers, read as they stand at that cycle, so a result written by an earlier element is visible to a later one.
- R6: done is high for exactly one cycle, the cycle after the last element. busy and rf_we are low outside the element cycles.
- R7: When n is 0, the block makes no write and done is high in the cycle right after the start cycle.
- R8: If any register number used by element i is NREG or more, element i makes no write and the loop ends. done follows in the next cycle with err high. err stays high until the next accepted start clears it.
- R9: start is ignored while a loop is running.
- R10: When all three operands are untagged and n > 1, the same destination is rewritten on every enabled element, and the value of the last enabled write remains.
- R11: After reset, busy, done, err and rf_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_rd | input | 5 | Destination base register |
| op_rs1 | input | 5 | First source base register |
| op_rs2 | input | 5 | Second source base register |
| op_pred | input | 5 | Register holding the predicate mask |
| glob_vl | input | 6 | Global vector length |
| vec_tag | input | 32 | Per-register vector tag |
| vec_len | input | 192 | Per-register length, 6 bits each, register r at bits [6r+5:6r] |
| rf_ra_addr | output | 5 | Read port A address (predicate when idle, first source when running) |
| rf_ra_data | input | 32 | Read port A data, combinational |
| rf_rb_addr | output | 5 | Read port B address (second source) |
| rf_rb_data | input | 32 | Read port B data, combinational |
| rf_we | output | 1 | Write enable |
| rf_wa | output | 5 | Write address |
| rf_wd | output | 32 | Write data |
| busy | output | 1 | Element loop running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Register number out of range, held until next start |

## Verification
The bench builds the block with its defaults: 32 registers and XLEN of 32, which gives 6-bit lengths. With these values a global length of 40 exceeds XLEN, so the clamp to 32 elements is reachable. A tagged base register near the top of the file also walks past register 31, which reaches the out-of-range stop. The full-width case runs 32 elements across the whole file, including the predicate register itself, which exercises the rule that the predicate is captured at start.

// File: rtl/pvs_pkg.sv
// Shared types for the predicated vector add sequencer.
package pvs_pkg;
    typedef enum logic [1:0] {
        PVS_IDLE = 2'd0,
        PVS_RUN  = 2'd1,
        PVS_FIN  = 2'd2
    } pvs_state_e;

    // operand slots: destination, first source, second source
    localparam int PVS_NOPS = 3;
    localparam int PVS_DST  = 0;
    localparam int PVS_SA   = 1;
    localparam int PVS_SB   = 2;
endpackage

// File: rtl/pvs_ctrl.sv
// Loop controller: works out the element count at start, steps one element
// per cycle, ends on the last element or on an out-of-range register.
// Assumes LW is wide enough to hold XLEN.
module pvs_ctrl
    import pvs_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int LW   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LW-1:0]    glob_vl,
    input  logic [LW-1:0]    dst_len,
    input  logic             oob,
    output logic             accept,
    output logic             step,
    output logic [LW-1:0]    elem,
    output logic             busy,
    output logic             done,
    output logic             err
);
    localparam logic [LW-1:0] XL = LW'(XLEN);

    pvs_state_e    state_q;
    logic [LW-1:0] last_q;
    logic [LW-1:0] lim_a;
    logic [LW-1:0] eff;

    // element count: smallest of global length, destination length, XLEN
    always_comb begin
        lim_a = (glob_vl < dst_len) ? glob_vl : dst_len;
        eff   = (lim_a > XL) ? XL : lim_a;
    end

    assign accept = (state_q == PVS_IDLE) && start;
    assign step   = (state_q == PVS_RUN);
    assign busy   = (state_q == PVS_RUN);
    assign done   = (state_q == PVS_FIN);

    // state, element counter and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PVS_IDLE;
            elem    <= '0;
            last_q  <= '0;
            err     <= 1'b0;
        end else begin
            case (state_q)
                PVS_IDLE: if (start) begin
                    err     <= 1'b0;
                    elem    <= '0;
                    last_q  <= eff - LW'(1);
                    state_q <= (eff == '0) ? PVS_FIN : PVS_RUN;
                end
                PVS_RUN: begin
                    if (oob) begin
                        err     <= 1'b1;
                        state_q <= PVS_FIN;
                    end else if (elem == last_q) begin
                        state_q <= PVS_FIN;
                    end else begin
                        elem <= elem + LW'(1);
                    end
                end
                default: state_q <= PVS_IDLE;
            endcase
        end
    end

    AST_ELEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && $past(step)) |-> (elem == $past(elem) + LW'(1))); // R1
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done); // R8
endmodule

// File: rtl/pvs_index.sv
// Register-number generator for one operand: captures base and tag at start;
// a tagged operand moves up one register per element, an untagged one stays.
// Assumes IW is wide enough for base plus the largest offset.
module pvs_index #(
    parameter int AW = 5,
    parameter int LW = 6,
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          tag,
    input  logic          adv,
    output logic [IW-1:0] idx
);
    logic [AW-1:0] base_q;
    logic          tag_q;
    logic [LW-1:0] off_q;

    // capture at start, advance the offset of tagged operands per element
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            tag_q  <= 1'b0;
            off_q  <= '0;
        end else if (load) begin
            base_q <= base;
            tag_q  <= tag;
            off_q  <= '0;
        end else if (adv && tag_q) begin
            off_q <= off_q + LW'(1);
        end
    end

    assign idx = IW'(base_q) + IW'(off_q);

    AST_SCALAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !tag_q && !load) |=> (idx == $past(idx))); // R3
    AST_VECTOR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && tag_q && !load) |=> (idx == $past(idx) + IW'(1))); // R4
endmodule

// File: rtl/pvs_lane.sv
// Element datapath: holds the predicate word captured at start, adds the two
// source values and gates the write with predicate bit elem.
module pvs_lane #(
    parameter int XLEN = 32,
    parameter int LW   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] pred_word,
    input  logic            step,
    input  logic            oob,
    input  logic [LW-1:0]   elem,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            we,
    output logic [XLEN-1:0] wd
);
    logic [XLEN-1:0] mask_q;
    logic            bit_on;

    // predicate capture at start
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '0;
        else if (load) mask_q <= pred_word;
    end

    // element enable and sum
    always_comb begin
        bit_on = |(mask_q & (XLEN'(1) << elem));
        we     = step && !oob && bit_on;
        wd     = src_a + src_b;
    end

    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> $stable(mask_q)); // R2
endmodule

// File: rtl/pvec_add_seq.sv
// Top of the predicated vector add sequencer. Connects the loop controller,
// three operand index generators and the element datapath to a register file
// with two combinational read ports and one write port.
// Assumes register data on the read ports is valid in the same cycle.
module pvec_add_seq
    import pvs_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    parameter int AW   = $clog2(NREG),
    parameter int LW   = $clog2(XLEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [AW-1:0]        op_rd,
    input  logic [AW-1:0]        op_rs1,
    input  logic [AW-1:0]        op_rs2,
    input  logic [AW-1:0]        op_pred,
    input  logic [LW-1:0]        glob_vl,
    input  logic [NREG-1:0]      vec_tag,
    input  logic [NREG*LW-1:0]   vec_len,
    output logic [AW-1:0]        rf_ra_addr,
    input  logic [XLEN-1:0]      rf_ra_data,
    output logic [AW-1:0]        rf_rb_addr,
    input  logic [XLEN-1:0]      rf_rb_data,
    output logic                 rf_we,
    output logic [AW-1:0]        rf_wa,
    output logic [XLEN-1:0]      rf_wd,
    output logic                 busy,
    output logic                 done,
    output logic                 err
);
    localparam int IW = ((AW > LW) ? AW : LW) + 1;

    logic          accept;
    logic          step;
    logic [LW-1:0] elem;
    logic          oob;
    logic [LW-1:0] dst_len;
    logic [AW-1:0] base_arr [PVS_NOPS];
    logic [IW-1:0] idx_arr  [PVS_NOPS];

    assign dst_len = vec_len[op_rd*LW +: LW];
    assign base_arr[PVS_DST] = op_rd;
    assign base_arr[PVS_SA]  = op_rs1;
    assign base_arr[PVS_SB]  = op_rs2;

    pvs_ctrl #(.XLEN(XLEN), .LW(LW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .glob_vl(glob_vl),
        .dst_len(dst_len), .oob(oob), .accept(accept), .step(step),
        .elem(elem), .busy(busy), .done(done), .err(err)
    );

    for (genvar g = 0; g < PVS_NOPS; g++) begin : g_opnd
        pvs_index #(.AW(AW), .LW(LW), .IW(IW)) u_idx (
            .clk(clk), .rst_n(rst_n), .load(accept), .base(base_arr[g]),
            .tag(vec_tag[base_arr[g]]), .adv(step), .idx(idx_arr[g])
        );
    end

    // any operand register number beyond the file
    always_comb begin
        oob = 1'b0;
        for (int k = 0; k < PVS_NOPS; k++)
            if (idx_arr[k] >= IW'(NREG)) oob = 1'b1;
    end

    // port A fetches the predicate when idle, the first source when running
    assign rf_ra_addr = step ? idx_arr[PVS_SA][AW-1:0] : op_pred;
    assign rf_rb_addr = idx_arr[PVS_SB][AW-1:0];
    assign rf_wa      = idx_arr[PVS_DST][AW-1:0];

    pvs_lane #(.XLEN(XLEN), .LW(LW)) u_lane (
        .clk(clk), .rst_n(rst_n), .load(accept), .pred_word(rf_ra_data),
        .step(step), .oob(oob), .elem(elem), .src_a(rf_ra_data),
        .src_b(rf_rb_data), .we(rf_we), .wd(rf_wd)
    );

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rf_we); // R6
    AST_NO_OOB_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !oob); // R8
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done)); // R9
endmodule

// File: tb/pvec_add_seq_tb.sv
`timescale 1ns/1ps
module pvec_add_seq_tb;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int AW   = 5;
    localparam int LW   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] op_rd = '0, op_rs1 = '0, op_rs2 = '0, op_pred = '0;
    logic [LW-1:0] glob_vl = '0;
    logic [NREG-1:0] vec_tag = '0;
    logic [NREG*LW-1:0] vec_len = '0;
    logic [AW-1:0] rf_ra_addr, rf_rb_addr, rf_wa;
    logic [XLEN-1:0] rf_ra_data, rf_rb_data, rf_wd;
    logic rf_we, busy, done, err;

    logic [XLEN-1:0] mem [NREG];
    logic [XLEN-1:0] ref_rf [NREG];
    logic poke_en = 1'b0;
    logic [AW-1:0] poke_addr = '0;
    logic [XLEN-1:0] poke_data = '0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pvec_add_seq #(.XLEN(XLEN), .NREG(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_rd(op_rd),
        .op_rs1(op_rs1), .op_rs2(op_rs2), .op_pred(op_pred),
        .glob_vl(glob_vl), .vec_tag(vec_tag), .vec_len(vec_len),
        .rf_ra_addr(rf_ra_addr), .rf_ra_data(rf_ra_data),
        .rf_rb_addr(rf_rb_addr), .rf_rb_data(rf_rb_data),
        .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd),
        .busy(busy), .done(done), .err(err)
    );

    // bench-side register file
    always @(posedge clk) begin
        if (poke_en)    mem[poke_addr] <= poke_data;
        else if (rf_we) mem[rf_wa] <= rf_wd;
    end
    assign rf_ra_data = mem[rf_ra_addr];
    assign rf_rb_data = mem[rf_rb_addr];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic poke(input int r, input logic [XLEN-1:0] v);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = AW'(r); poke_data = v;
        @(negedge clk);
        poke_en = 1'b0;
        ref_rf[r] = v;
    endtask

    task automatic set_tag(input int r, input bit t, input int len);
        vec_tag[r] = t;
        vec_len[r*LW +: LW] = LW'(len);
    endtask

    function automatic int len_of(input int r);
        return int'(vec_len[r*LW +: LW]);
    endfunction

    // one operation: reference model stepped cycle by cycle
    task automatic run_op(input int rd, input int rs1, input int rs2,
                          input int pr, input int vl, input string req,
                          input bit mid_start);
        int n;
        bit exp_err;
        logic [XLEN-1:0] mask;
        int bad_regs;
        @(negedge clk);
        chk(!busy && !done && !rf_we, "R6", "idle before start", {busy, done, rf_we}, 0);
        op_rd = AW'(rd); op_rs1 = AW'(rs1); op_rs2 = AW'(rs2); op_pred = AW'(pr);
        glob_vl = LW'(vl); start = 1'b1;
        n = vl;
        if (len_of(rd) < n) n = len_of(rd);
        if (n > XLEN) n = XLEN;
        mask = ref_rf[pr];
        exp_err = 0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            int d = rd  + (vec_tag[rd]  ? i : 0);
            int a = rs1 + (vec_tag[rs1] ? i : 0);
            int b = rs2 + (vec_tag[rs2] ? i : 0);
            chk(busy && !done, "R1", "busy during element", {busy, done}, 2'b10);
            if (d >= NREG || a >= NREG || b >= NREG) begin
                chk(!rf_we, "R8", "write on out-of-range element", rf_we, 0);
                exp_err = 1;
                @(negedge clk);
                break;
            end
            chk(rf_we == mask[i], (req == "R10") ? "R10" : "R2", "write enable", rf_we, mask[i]);
            if (mask[i]) begin
                chk(rf_wa == AW'(d), "R3", "dest register", rf_wa, d);
                chk(rf_wd == ref_rf[a] + ref_rf[b], "R5", "sum", rf_wd, ref_rf[a] + ref_rf[b]);
                ref_rf[d] = ref_rf[a] + ref_rf[b];
            end
            if (mid_start && i == 1) begin
                start = 1'b1; op_rd = 5'd3; op_pred = 5'd4; glob_vl = 6'd1;
            end
            if (mid_start && i == 2) start = 1'b0;
            @(negedge clk);
        end
        chk(done && !busy, (n == 0) ? "R7" : "R6", "done after loop", {done, busy}, 2'b10);
        chk(err == exp_err, "R8", "err flag", err, exp_err);
        @(negedge clk);
        chk(!done, "R6", "done single pulse", done, 0);
        bad_regs = 0;
        for (int k = 0; k < NREG; k++) if (mem[k] !== ref_rf[k]) bad_regs++;
        chk(bad_regs == 0, req, "register file contents", bad_regs, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && !rf_we, "R11", "reset state",
            {busy, done, err, rf_we}, 0);
        for (int k = 0; k < NREG; k++) poke(k, 32'h0103_0507 * k + 32'h11);
        poke(1, 32'hFFFF_FFFF);
        poke(2, 32'h0000_000A);
        poke(3, 32'h0000_0016);
        poke(4, 32'h0000_0000);
        set_tag(8, 1, 4);  set_tag(16, 1, 8); set_tag(20, 1, 8);
        set_tag(24, 1, 6); set_tag(5, 0, 5);  set_tag(0, 1, 63);
        set_tag(30, 1, 5);
        run_op(8, 16, 20, 1, 8, "R1", 0);   // vector-vector, all enabled
        run_op(8, 16, 20, 2, 8, "R4", 0);   // mask 1010: skip, offsets still advance
        run_op(24, 5, 16, 1, 9, "R3", 0);   // scalar first source
        run_op(5, 5, 7, 3, 9, "R10", 0);    // all scalar, accumulate, mask 10110
        run_op(8, 16, 20, 1, 0, "R7", 0);   // zero length
        run_op(8, 16, 20, 4, 8, "R2", 0);   // all-zero predicate: no writes
        run_op(0, 9, 10, 1, 40, "R1", 0);   // clamp to XLEN, overwrites r1 mid-run
        poke(1, 32'hFFFF_FFFF);
        run_op(30, 16, 20, 1, 8, "R8", 0);  // walks past the last register
        run_op(8, 16, 20, 1, 8, "R9", 1);   // start pulsed mid-run; err cleared
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule